// File: doc/BRIEF.md
# Interrupt Destination Set Resolver

This block takes one routing request from an interrupt redirection stage and turns it into per-target injection strobes for up to sixteen processor targets. A request carries an 8-bit destination, an addressing-mode bit (physical or logical), a 3-bit delivery code, the vector, the trigger kind (edge or level) and the source pin index. Each target is described by three static configuration inputs: a present flag, an 8-bit physical identifier and a logical-match bit. The logical-match bit is the result of that target's own logical address comparison, done outside this block.

The resolver first builds the set of addressed targets. It then trims that set according to the delivery code and the pin-0 rule, and loads what is left into a pending register. From the pending register it emits one strobe per cycle, lowest target first. While strobes are pending it raises `busy`, and it drops any request that arrives in that time. A request whose delivery code it cannot serve produces no strobe. Instead it raises a one-cycle `unsupported` flag.

Top module: `irq_dest_resolver`

## Requirements
- R1: After reset, `inj_valid` is all zero and `busy` and `unsupported` are low.
- R2: In physical mode, when the destination is not 8'hFF, the set holds at most one target: the lowest-numbered present target whose physical ID equals the destination. Absent targets are skipped even if their ID matches.
- R3: In physical mode, a destination of 8'hFF addresses every present target.
- R4: In logical mode, a destination of 8'h00 addresses no target.
- R5: In logical mode with a nonzero destination, the set holds every target that is both present and has its logical-match bit set.
- R6: With delivery code 3'd0 (fixed), every target in the set is strobed exactly once, in ascending index order, one target per cycle. The first strobe appears in the cycle after the request is accepted. Each strobe carries the request's vector and trigger kind. `busy` is high in every strobe cycle and low once the last strobe has been issued.
- R7: A request whose resulting set is empty produces no strobe and leaves `busy` low.
- R8: With delivery code 3'd1 (lowest priority), only the lowest-numbered target of the set is strobed.
- R9: For a request from pin 0 with a nonempty set, both fixed and lowest-priority delivery strobe target 0 alone, provided target 0 is present. If target 0 is absent, nothing is strobed.
- R10: Delivery codes 3'd2 to 3'd7 produce no strobe and leave `busy` low. `unsupported` is high for exactly the one cycle after acceptance.
- R11: A request presented while `busy` is high is ignored. This includes a request presented during the final strobe cycle. The strobes already in progress continue unchanged, and no strobe follows them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Routing request present; accepted when `busy` is low |
| req_dest | input | 8 | Destination field |
| req_logical | input | 1 | 0 = physical addressing, 1 = logical addressing |
| req_dmode | input | 3 | Delivery code: 0 fixed, 1 lowest priority, others unsupported |
| req_vector | input | 8 | Vector to inject |
| req_level | input | 1 | Trigger kind: 1 = level, 0 = edge |
| req_pin | input | 5 | Source pin index |
| tgt_present | input | 16 | Per-target present flags |
| tgt_phys_id | input | 128 | Per-target physical IDs; target i occupies bits [8i+7:8i] |
| tgt_logical_hit | input | 16 | Per-target logical-match result |
| busy | output | 1 | Strobes still pending |
| inj_valid | output | 16 | One-hot injection strobe, bit i = target i |
| inj_vector | output | 8 | Vector accompanying the strobe |
| inj_level | output | 1 | Trigger kind accompanying the strobe |
| unsupported | output | 1 | One-cycle flag for an unserviceable delivery code |

## Verification
The two functions that can meet in one cycle are acceptance of a new request and the issue of a pending strobe, the final strobe in particular. The bench starts a four-target fixed delivery and holds a different request on the input for the whole run, including the final strobe cycle. It then removes that request the moment `busy` falls. The result is judged at the ports: the strobe sequence and its vector must be exactly those of the first request, and no strobe may follow it.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;

    localparam int TGT_N   = 16;
    localparam int DEST_W  = 8;
    localparam int VEC_W   = 8;
    localparam int PIN_W   = 5;
    localparam int DMODE_W = 3;

    localparam int ID_BUS_W = TGT_N * DEST_W;

    typedef logic [TGT_N-1:0]   tmask_t;
    typedef logic [DEST_W-1:0]  dest_t;
    typedef logic [VEC_W-1:0]   vec_t;
    typedef logic [PIN_W-1:0]   pin_t;
    typedef logic [DMODE_W-1:0] dmode_t;

    localparam dmode_t DM_FIXED  = dmode_t'(0);
    localparam dmode_t DM_LOWPRI = dmode_t'(1);

    localparam dest_t DEST_ALL  = {DEST_W{1'b1}};
    localparam dest_t DEST_NONE = '0;

    typedef struct packed {
        dest_t  dest;
        logic   logical;
        dmode_t dmode;
        vec_t   vector;
        logic   level;
        pin_t   pin;
    } route_req_t;

    // Isolate the least significant set bit of a target mask.
    function automatic tmask_t lowest_bit(input tmask_t m);
        return m & (~m + tmask_t'(1));
    endfunction

endpackage

// File: rtl/irq_dest_match.sv
module irq_dest_match
    import irq_dest_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  dest_t               dest,
    input  logic                logical,
    input  tmask_t              present,
    input  logic [ID_BUS_W-1:0] phys_ids,
    input  tmask_t              logic_hit,
    output tmask_t              dset
);

    tmask_t id_hit;

    for (genvar i = 0; i < TGT_N; i++) begin : g_idcmp
        assign id_hit[i] = present[i] && (phys_ids[i*DEST_W +: DEST_W] == dest);
    end

    always_comb begin
        if (!logical) begin
            if (dest == DEST_ALL) dset = present;
            else                  dset = lowest_bit(id_hit);
        end else begin
            if (dest == DEST_NONE) dset = '0;
            else                   dset = present & logic_hit;
        end
    end

    // R2: a non-broadcast physical lookup never names more than one target
    p_phys_single_r2: assert property (@(posedge clk) disable iff (rst)
        (!logical && dest != DEST_ALL) |-> $onehot0(dset));

    // R4: logical destination zero reaches nobody
    p_logical_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (logical && dest == DEST_NONE) |-> (dset == '0));

    // R5: every logically addressed target is present
    p_logical_present_r5: assert property (@(posedge clk) disable iff (rst)
        logical |-> ((dset & ~present) == '0));

endmodule

// File: rtl/irq_mode_filter.sv
module irq_mode_filter
    import irq_dest_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  tmask_t dset,
    input  dmode_t dmode,
    input  pin_t   pin,
    input  tmask_t present,
    output tmask_t load_set,
    output logic   unsup
);

    tmask_t only_t0;
    logic   pin0_rule;

    always_comb begin
        only_t0    = '0;
        only_t0[0] = present[0];
    end

    assign pin0_rule = (pin == '0) && (dset != '0);

    always_comb begin
        load_set = '0;
        unsup    = 1'b0;
        unique case (dmode)
            DM_FIXED:  load_set = pin0_rule ? only_t0 : dset;
            DM_LOWPRI: load_set = pin0_rule ? only_t0 : lowest_bit(dset);
            default:   unsup    = 1'b1;
        endcase
    end

    // R8: lowest-priority delivery names at most one target
    p_lowpri_single_r8: assert property (@(posedge clk) disable iff (rst)
        (dmode == DM_LOWPRI) |-> $onehot0(load_set));

    // R10: an unserviceable code loads nothing
    p_unsup_empty_r10: assert property (@(posedge clk) disable iff (rst)
        unsup |-> (load_set == '0));

endmodule

// File: rtl/irq_inject_seq.sv
module irq_inject_seq
    import irq_dest_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  tmask_t load_set,
    input  vec_t   load_vec,
    input  logic   load_lvl,
    input  logic   load_unsup,
    output logic   busy,
    output tmask_t strobe,
    output vec_t   strobe_vec,
    output logic   strobe_lvl,
    output logic   unsup_flag
);

    tmask_t pending_q;
    vec_t   vec_q;
    logic   lvl_q;
    logic   unsup_q;

    assign strobe     = lowest_bit(pending_q);
    assign busy       = (pending_q != '0);
    assign strobe_vec = vec_q;
    assign strobe_lvl = lvl_q;
    assign unsup_flag = unsup_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= '0;
            vec_q     <= '0;
            lvl_q     <= 1'b0;
            unsup_q   <= 1'b0;
        end else begin
            unsup_q <= 1'b0;
            if (load) begin
                pending_q <= load_set;
                vec_q     <= load_vec;
                lvl_q     <= load_lvl;
                unsup_q   <= load_unsup;
            end else begin
                pending_q <= pending_q & ~strobe;
            end
        end
    end

    // R11: while busy, no new target can enter the pending set
    p_ignore_busy_r11: assert property (@(posedge clk) disable iff (rst)
        busy |=> ((pending_q & ~$past(pending_q)) == '0));

    // R6: consecutive strobes climb in target index
    p_ascend_r6: assert property (@(posedge clk) disable iff (rst)
        ((strobe != '0) && ($past(strobe) != '0)) |-> (strobe > $past(strobe)));

    // R10: the unsupported flag never coincides with pending work
    p_unsup_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        unsup_q |-> !busy);

    // R10: the flag lasts a single cycle
    p_unsup_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        unsup_q |=> !unsup_q);

endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
    import irq_dest_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [DEST_W-1:0]   req_dest,
    input  logic                req_logical,
    input  logic [DMODE_W-1:0]  req_dmode,
    input  logic [VEC_W-1:0]    req_vector,
    input  logic                req_level,
    input  logic [PIN_W-1:0]    req_pin,
    input  logic [TGT_N-1:0]    tgt_present,
    input  logic [ID_BUS_W-1:0] tgt_phys_id,
    input  logic [TGT_N-1:0]    tgt_logical_hit,
    output logic                busy,
    output logic [TGT_N-1:0]    inj_valid,
    output logic [VEC_W-1:0]    inj_vector,
    output logic                inj_level,
    output logic                unsupported
);

    route_req_t req;
    tmask_t     addr_set;
    tmask_t     load_set;
    logic       load_unsup;
    logic       accept;

    assign req = '{dest:    req_dest,
                   logical: req_logical,
                   dmode:   req_dmode,
                   vector:  req_vector,
                   level:   req_level,
                   pin:     req_pin};

    assign accept = req_valid && !busy;

    irq_dest_match u_match (
        .clk       (clk),
        .rst       (rst),
        .dest      (req.dest),
        .logical   (req.logical),
        .present   (tgt_present),
        .phys_ids  (tgt_phys_id),
        .logic_hit (tgt_logical_hit),
        .dset      (addr_set)
    );

    irq_mode_filter u_filter (
        .clk      (clk),
        .rst      (rst),
        .dset     (addr_set),
        .dmode    (req.dmode),
        .pin      (req.pin),
        .present  (tgt_present),
        .load_set (load_set),
        .unsup    (load_unsup)
    );

    irq_inject_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .load_set   (load_set),
        .load_vec   (req.vector),
        .load_lvl   (req.level),
        .load_unsup (load_unsup),
        .busy       (busy),
        .strobe     (inj_valid),
        .strobe_vec (inj_vector),
        .strobe_lvl (inj_level),
        .unsup_flag (unsupported)
    );

    // R6: any strobe names a target that is present
    p_strobe_present_r6: assert property (@(posedge clk) disable iff (rst)
        ((inj_valid & ~tgt_present) == '0) || !$stable(tgt_present));

endmodule

// File: tb/tb_irq_dest_resolver.sv
`timescale 1ns/1ps
module tb_irq_dest_resolver;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [7:0]    req_dest = '0;
    logic          req_logical = 1'b0;
    logic [2:0]    req_dmode = '0;
    logic [7:0]    req_vector = '0;
    logic          req_level = 1'b0;
    logic [4:0]    req_pin = '0;
    logic [15:0]   tgt_present = '0;
    logic [127:0]  tgt_phys_id = '0;
    logic [15:0]   tgt_logical_hit = '0;
    logic          busy;
    logic [15:0]   inj_valid;
    logic [7:0]    inj_vector;
    logic          inj_level;
    logic          unsupported;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_dest_resolver dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_dest(req_dest),
        .req_logical(req_logical), .req_dmode(req_dmode), .req_vector(req_vector),
        .req_level(req_level), .req_pin(req_pin), .tgt_present(tgt_present),
        .tgt_phys_id(tgt_phys_id), .tgt_logical_hit(tgt_logical_hit),
        .busy(busy), .inj_valid(inj_valid), .inj_vector(inj_vector),
        .inj_level(inj_level), .unsupported(unsupported)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_ids();
        for (int i = 0; i < 16; i++) tgt_phys_id[i*8 +: 8] = 8'h40 + 8'(i);
        tgt_phys_id[5*8 +: 8] = 8'h77;
        tgt_phys_id[9*8 +: 8] = 8'h77;
    endtask

    task automatic drive(input logic [7:0] d, input logic lg, input logic [2:0] dm,
                         input logic [7:0] v, input logic lv, input logic [4:0] p);
        req_dest = d; req_logical = lg; req_dmode = dm;
        req_vector = v; req_level = lv; req_pin = p;
    endtask

    // Issue one request, then follow every expected strobe in ascending order.
    task automatic run_req(input logic [7:0] d, input logic lg, input logic [2:0] dm,
                           input logic [7:0] v, input logic lv, input logic [4:0] p,
                           input logic [15:0] exp, input bit exp_unsup, input string tag);
        logic [15:0] rem;
        logic [15:0] lo;
        @(negedge clk);
        drive(d, lg, dm, v, lv, p);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(unsupported == exp_unsup, {tag, " unsupported flag"}, 32'(unsupported), 32'(exp_unsup));
        rem = exp;
        while (rem != '0) begin
            lo = rem & (~rem + 16'd1);
            check(inj_valid == lo, {tag, " strobe"}, 32'(inj_valid), 32'(lo));
            check(inj_vector == v && inj_level == lv && busy,
                  {tag, " strobe payload/busy"}, {15'd0, busy, inj_level, inj_vector},
                  {15'd0, 1'b1, lv, v});
            rem = rem & ~lo;
            @(negedge clk);
        end
        check(inj_valid == '0 && !busy, {tag, " idle after set"}, {15'd0, busy, inj_valid}, 32'd0);
        if (exp_unsup) begin
            @(negedge clk);
            check(!unsupported, {tag, " unsupported one cycle"}, 32'(unsupported), 32'd0);
        end
    endtask

    task automatic t_reset();
        check(inj_valid == '0 && !busy && !unsupported, "R1 reset state",
              {14'd0, unsupported, busy, inj_valid}, 32'd0);
    endtask

    task automatic t_phys_first();
        tgt_present = 16'hEFDE;
        run_req(8'h77, 1'b0, 3'd0, 8'h31, 1'b1, 5'd3, 16'h0200, 1'b0, "R2 absent match skipped");
        tgt_present = 16'hFFFF;
        run_req(8'h77, 1'b0, 3'd0, 8'h32, 1'b0, 5'd3, 16'h0020, 1'b0, "R2 first match wins");
        run_req(8'h4C, 1'b0, 3'd0, 8'h33, 1'b0, 5'd3, 16'h1000, 1'b0, "R2 single id match");
    endtask

    task automatic t_broadcast();
        tgt_present = 16'hEFDE;
        run_req(8'hFF, 1'b0, 3'd0, 8'hA1, 1'b1, 5'd4, 16'hEFDE, 1'b0, "R3 R6 broadcast sequence");
    endtask

    task automatic t_logical();
        tgt_present = 16'hEFDE;
        tgt_logical_hit = 16'hFFFF;
        run_req(8'h00, 1'b1, 3'd0, 8'h22, 1'b0, 5'd2, 16'h0000, 1'b0, "R4 R7 logical zero");
        tgt_logical_hit = 16'h0F0F;
        run_req(8'h12, 1'b1, 3'd0, 8'h5A, 1'b1, 5'd2, 16'h0F0E, 1'b0, "R5 R6 logical set");
    endtask

    task automatic t_empty();
        tgt_present = 16'hFFFF;
        run_req(8'h99, 1'b0, 3'd0, 8'h10, 1'b0, 5'd6, 16'h0000, 1'b0, "R7 no physical match");
    endtask

    task automatic t_lowpri();
        tgt_present = 16'hEFDE;
        tgt_logical_hit = 16'h0F0C;
        run_req(8'h03, 1'b1, 3'd1, 8'h61, 1'b1, 5'd7, 16'h0004, 1'b0, "R8 lowest of logical set");
        run_req(8'hFF, 1'b0, 3'd1, 8'h62, 1'b0, 5'd7, 16'h0002, 1'b0, "R8 lowest of broadcast");
    endtask

    task automatic t_pin0();
        tgt_present = 16'hFFFF;
        run_req(8'hFF, 1'b0, 3'd0, 8'h70, 1'b0, 5'd0, 16'h0001, 1'b0, "R9 pin0 fixed");
        tgt_logical_hit = 16'h0F00;
        run_req(8'h08, 1'b1, 3'd1, 8'h71, 1'b1, 5'd0, 16'h0001, 1'b0, "R9 pin0 lowest priority");
        tgt_present = 16'hEFDE;
        run_req(8'hFF, 1'b0, 3'd0, 8'h72, 1'b0, 5'd0, 16'h0000, 1'b0, "R9 pin0 target0 absent");
        run_req(8'h00, 1'b1, 3'd0, 8'h73, 1'b0, 5'd0, 16'h0000, 1'b0, "R9 pin0 empty set");
    endtask

    task automatic t_unsup();
        tgt_present = 16'hFFFF;
        run_req(8'hFF, 1'b0, 3'd2, 8'h80, 1'b0, 5'd1, 16'h0000, 1'b1, "R10 code 2");
        run_req(8'hFF, 1'b0, 3'd5, 8'h81, 1'b0, 5'd1, 16'h0000, 1'b1, "R10 code 5");
        run_req(8'hFF, 1'b0, 3'd7, 8'h82, 1'b1, 5'd1, 16'h0000, 1'b1, "R10 code 7");
    endtask

    // A competing request is held across every strobe, the final one included.
    task automatic t_busy_overlap();
        logic [15:0] rem;
        logic [15:0] lo;
        tgt_present = 16'h8421;
        @(negedge clk);
        drive(8'hFF, 1'b0, 3'd0, 8'hC3, 1'b1, 5'd9);
        req_valid = 1'b1;
        @(negedge clk);
        drive(8'h40, 1'b0, 3'd0, 8'h55, 1'b0, 5'd2);
        rem = 16'h8421;
        while (rem != '0) begin
            lo = rem & (~rem + 16'd1);
            check(inj_valid == lo && inj_vector == 8'hC3, "R11 strobe during competing request",
                  {8'd0, inj_vector, inj_valid}, {8'd0, 8'hC3, lo});
            rem = rem & ~lo;
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(inj_valid == '0 && !busy, "R11 idle after overlap", {15'd0, busy, inj_valid}, 32'd0);
        @(negedge clk);
        check(inj_valid == '0 && !busy, "R11 competing request dropped", {15'd0, busy, inj_valid}, 32'd0);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        set_ids();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_phys_first();
        t_broadcast();
        t_logical();
        t_empty();
        t_lowpri();
        t_pin0();
        t_unsup();
        t_busy_overlap();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule